// File: doc/BRIEF.md
# Logical Port Polling Sequencer

This block steps through a window of logical identifiers and looks each one up in a remap table that holds a downstream port number and an enable bit for that identifier. It puts the port number on a poll address output so the downstream device can report whether that port can take data. It then picks up the device's answer a fixed number of cycles later and turns a positive answer into a grant. The grant names the port and the identifier that should receive the next burst. Polling runs only while both the link-mode flag and the packet-level flag are set.

The grant output is a valid/ready stream. When `grant_valid` is high, `grant_port` and `grant_id` are frozen until the transmitter raises `grant_ready` in the same cycle. Positive answers that arrive while an untaken grant is occupying the slot are dropped rather than queued. The scan comes back to those identifiers on its next pass. The slot reloads in the same cycle as a handshake, so a transmitter that always accepts can see one grant per cycle. When the multiple-burst flag is clear, a port that has just been granted must show up in a fresh poll before it can be granted again.

Top module: `lp_poll_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `poll_valid` and `grant_valid` are low. Every remap entry resets to port 0 with its enable bit clear.
- R2: Polling is active only when `link_mode` and `pkt_mode` are both high. In the cycle after an inactive edge, `poll_valid` is low, and no new grant is loaded at an inactive edge. When polling becomes active again, the first poll shown is identifier 0.
- R3: While active, one identifier is polled per cycle in ascending order from 0 to `poll_limit` inclusive, and the scan then wraps to 0. A `poll_limit` of 0 polls identifier 0 every cycle. `poll_addr` carries the port stored for that identifier, and `poll_valid` equals that entry's enable bit.
- R4: A table write (`tbl_wr_en` high at a clock edge) replaces the entry at `tbl_wr_id`. Every poll shown after that edge uses the new port and enable values.
- R5: The poll shown during cycle n is answered by the value of `port_avail` at the end of cycle n+1. This is the edge two cycles after the poll address was driven.
- R6: An identifier whose enable bit is clear is never granted, even when `port_avail` is high.
- R7: While `grant_valid` is high and `grant_ready` is low, `grant_valid`, `grant_port` and `grant_id` hold their values.
- R8: A positive answer that arrives while the grant slot is full and not being taken is discarded. A positive answer that arrives in a handshake cycle loads the slot at that same edge.
- R9: When `multi_burst_en` is low and port P is handed off, P is not granted again until a poll of P shown after the handshake cycle is answered as available. With a single enabled identifier, a continuously available port and an always-ready transmitter, this gives exactly one grant every three cycles.
- R10: When `multi_burst_en` is high, the same port may be granted in back-to-back cycles. With a single enabled identifier, a continuously available port and an always-ready transmitter, `grant_valid` stays high.
- R11: If `poll_limit` is lowered below the identifier currently being scanned, the scan wraps to identifier 0 right after polling the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_mode | input | 1 | Link-mode flag |
| pkt_mode | input | 1 | Packet-level mode flag |
| poll_limit | input | ID_W | Highest identifier polled |
| multi_burst_en | input | 1 | Allows repeat grants to one port without a re-poll |
| tbl_wr_en | input | 1 | Remap table write strobe |
| tbl_wr_id | input | ID_W | Entry to write |
| tbl_wr_port | input | PORT_W | Port number to store |
| tbl_wr_enable | input | 1 | Enable bit to store |
| poll_valid | output | 1 | Poll address is meaningful this cycle |
| poll_addr | output | PORT_W | Port being polled |
| port_avail | input | 1 | Downstream answer for the poll two cycles back |
| grant_valid | output | 1 | Grant stream valid |
| grant_ready | input | 1 | Grant stream ready (transmitter takes the grant) |
| grant_port | output | PORT_W | Granted port |
| grant_id | output | ID_W | Identifier that produced the grant |

## Verification
The bench builds the block with its defaults: 64 identifiers, 6-bit ports and a two-cycle answer latency. With these values a full scan of every identifier and scan limits of 0, 1, 3, 5 and 63 can all be exercised. A limit of 0 with one enabled identifier pins the re-poll spacing to an exact three-cycle period, which makes R9 and R10 countable. An alternating two-identifier scan with only one port answering makes any error in the answer latency show up as a wrong grant. A behavioural model built from queues tracks the polls in flight and the per-port re-poll state, and it predicts every output on every clock under held, random and always-ready transmitters.

// File: rtl/lps_pkg.sv
package lps_pkg;

  localparam int unsigned LPS_DEF_IDS    = 64;
  localparam int unsigned LPS_DEF_PORT_W = 6;
  localparam int unsigned LPS_DEF_LAT    = 2;

  // True when the scan has reached (or passed) its upper bound.
  function automatic logic lps_at_end(input int unsigned cur, input int unsigned lim);
    return cur >= lim;
  endfunction

endpackage

// File: rtl/lps_map_table.sv
module lps_map_table #(
  parameter int unsigned NUM_IDS = 64,
  parameter int unsigned ID_W    = 6,
  parameter int unsigned PORT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              wr_enable,
  input  logic [ID_W-1:0]   rd_id,
  output logic [PORT_W-1:0] rd_port,
  output logic              rd_enable
);

  logic [PORT_W-1:0] ent_port [NUM_IDS];
  logic [NUM_IDS-1:0] ent_en;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_entry
    logic [PORT_W-1:0] port_r;
    logic              en_r;
    logic              hit;

    assign hit = wr_en && (wr_id == ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        port_r <= '0;
        en_r   <= 1'b0;
      end else if (hit) begin
        port_r <= wr_port;
        en_r   <= wr_enable;
      end
    end

    assign ent_port[g] = port_r;
    assign ent_en[g]   = en_r;
  end

  assign rd_port   = ent_port[rd_id];
  assign rd_enable = ent_en[rd_id];

endmodule

// File: rtl/lps_scan_ptr.sv
module lps_scan_ptr #(
  parameter int unsigned ID_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [ID_W-1:0] limit,
  output logic [ID_W-1:0] cur_id
);

  logic wrap;

  assign wrap = lps_pkg::lps_at_end(int'(cur_id), int'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_id <= '0;
    end else if (!active) begin
      cur_id <= '0;
    end else if (wrap) begin
      cur_id <= '0;
    end else begin
      cur_id <= cur_id + ID_W'(1);
    end
  end

endmodule

// File: rtl/lps_poll_pipe.sv
module lps_poll_pipe #(
  parameter int unsigned ID_W   = 6,
  parameter int unsigned PORT_W = 6,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [ID_W-1:0]   in_id,
  input  logic [PORT_W-1:0] in_port,
  input  logic              in_en,
  output logic              head_valid,
  output logic [PORT_W-1:0] head_port,
  output logic              head_en,
  output logic              tail_valid,
  output logic [ID_W-1:0]   tail_id,
  output logic [PORT_W-1:0] tail_port,
  output logic              tail_en
);

  logic [DEPTH-1:0]  st_vld;
  logic [DEPTH-1:0]  st_en;
  logic [ID_W-1:0]   st_id   [DEPTH];
  logic [PORT_W-1:0] st_port [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic              nxt_vld;
    logic              nxt_en;
    logic [ID_W-1:0]   nxt_id;
    logic [PORT_W-1:0] nxt_port;
    logic              vld_r;
    logic              en_r;
    logic [ID_W-1:0]   id_r;
    logic [PORT_W-1:0] port_r;

    if (s == 0) begin : g_first
      assign nxt_vld  = 1'b1;
      assign nxt_en   = in_en;
      assign nxt_id   = in_id;
      assign nxt_port = in_port;
    end else begin : g_next
      assign nxt_vld  = st_vld[s-1];
      assign nxt_en   = st_en[s-1];
      assign nxt_id   = st_id[s-1];
      assign nxt_port = st_port[s-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
        vld_r  <= 1'b0;
        en_r   <= 1'b0;
        id_r   <= '0;
        port_r <= '0;
      end else begin
        vld_r  <= nxt_vld;
        en_r   <= nxt_en;
        id_r   <= nxt_id;
        port_r <= nxt_port;
      end
    end

    assign st_vld[s]  = vld_r;
    assign st_en[s]   = en_r;
    assign st_id[s]   = id_r;
    assign st_port[s] = port_r;
  end

  assign head_valid = st_vld[0];
  assign head_port  = st_port[0];
  assign head_en    = st_en[0];
  assign tail_valid = st_vld[DEPTH-1];
  assign tail_id    = st_id[DEPTH-1];
  assign tail_port  = st_port[DEPTH-1];
  assign tail_en    = st_en[DEPTH-1];

endmodule

// File: rtl/lps_grant_arb.sv
module lps_grant_arb #(
  parameter int unsigned ID_W   = 6,
  parameter int unsigned PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              multi_burst_en,
  input  logic              samp_valid,
  input  logic [ID_W-1:0]   samp_id,
  input  logic [PORT_W-1:0] samp_port,
  input  logic              samp_en,
  input  logic              port_avail,
  input  logic              poll_valid,
  input  logic [PORT_W-1:0] poll_addr,
  input  logic              grant_ready,
  output logic              grant_valid,
  output logic [PORT_W-1:0] grant_port,
  output logic [ID_W-1:0]   grant_id
);

  localparam int unsigned NUM_PORTS = 1 << PORT_W;

  logic [NUM_PORTS-1:0] needs_poll;
  logic                 handoff;
  logic                 slot_free;
  logic                 repoll_ok;
  logic                 cand;

  assign handoff   = grant_valid && grant_ready;
  assign slot_free = !grant_valid || grant_ready;

  // A port just handed off (this edge or earlier) must be seen in a fresh poll.
  assign repoll_ok = multi_burst_en ||
                     (!needs_poll[samp_port] && !(handoff && (grant_port == samp_port)));

  assign cand = active && samp_valid && samp_en && port_avail && repoll_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_port  <= '0;
      grant_id    <= '0;
    end else if (slot_free) begin
      grant_valid <= cand;
      if (cand) begin
        grant_port <= samp_port;
        grant_id   <= samp_id;
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic flag_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_r <= 1'b0;
      end else if (handoff && (grant_port == PORT_W'(p))) begin
        flag_r <= 1'b1;
      end else if (poll_valid && (poll_addr == PORT_W'(p))) begin
        flag_r <= 1'b0;
      end
    end
    assign needs_poll[p] = flag_r;
  end

endmodule

// File: rtl/lp_poll_seq.sv
module lp_poll_seq #(
  parameter int unsigned NUM_IDS  = lps_pkg::LPS_DEF_IDS,
  parameter int unsigned PORT_W   = lps_pkg::LPS_DEF_PORT_W,
  parameter int unsigned POLL_LAT = lps_pkg::LPS_DEF_LAT,
  localparam int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_mode,
  input  logic              pkt_mode,
  input  logic [ID_W-1:0]   poll_limit,
  input  logic              multi_burst_en,
  input  logic              tbl_wr_en,
  input  logic [ID_W-1:0]   tbl_wr_id,
  input  logic [PORT_W-1:0] tbl_wr_port,
  input  logic              tbl_wr_enable,
  output logic              poll_valid,
  output logic [PORT_W-1:0] poll_addr,
  input  logic              port_avail,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [PORT_W-1:0] grant_port,
  output logic [ID_W-1:0]   grant_id
);

  logic              active;
  logic [ID_W-1:0]   cur_id;
  logic [PORT_W-1:0] rd_port;
  logic              rd_enable;
  logic              head_valid;
  logic [PORT_W-1:0] head_port;
  logic              head_en;
  logic              tail_valid;
  logic [ID_W-1:0]   tail_id;
  logic [PORT_W-1:0] tail_port;
  logic              tail_en;

  assign active = link_mode && pkt_mode;

  lps_map_table #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .PORT_W(PORT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_id(tbl_wr_id), .wr_port(tbl_wr_port), .wr_enable(tbl_wr_enable),
    .rd_id(cur_id), .rd_port(rd_port), .rd_enable(rd_enable)
  );

  lps_scan_ptr #(.ID_W(ID_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .active(active), .limit(poll_limit), .cur_id(cur_id)
  );

  lps_poll_pipe #(.ID_W(ID_W), .PORT_W(PORT_W), .DEPTH(POLL_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .active(active),
    .in_id(cur_id), .in_port(rd_port), .in_en(rd_enable),
    .head_valid(head_valid), .head_port(head_port), .head_en(head_en),
    .tail_valid(tail_valid), .tail_id(tail_id), .tail_port(tail_port), .tail_en(tail_en)
  );

  assign poll_valid = head_valid && head_en;
  assign poll_addr  = head_port;

  lps_grant_arb #(.ID_W(ID_W), .PORT_W(PORT_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .active(active), .multi_burst_en(multi_burst_en),
    .samp_valid(tail_valid), .samp_id(tail_id), .samp_port(tail_port), .samp_en(tail_en),
    .port_avail(port_avail), .poll_valid(poll_valid), .poll_addr(poll_addr),
    .grant_ready(grant_ready), .grant_valid(grant_valid),
    .grant_port(grant_port), .grant_id(grant_id)
  );

endmodule

// File: rtl/lp_poll_seq_chk.sv
module lp_poll_seq_chk #(
  parameter int unsigned ID_W   = 6,
  parameter int unsigned PORT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_mode,
  input logic              pkt_mode,
  input logic              multi_burst_en,
  input logic              port_avail,
  input logic              poll_valid,
  input logic              grant_valid,
  input logic              grant_ready,
  input logic [PORT_W-1:0] grant_port,
  input logic [ID_W-1:0]   grant_id
);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!poll_valid && !grant_valid));

  assert_poll_off_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_mode && pkt_mode) |=> !poll_valid);

  assert_no_grant_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(link_mode && pkt_mode) && (!grant_valid || grant_ready)) |=> !grant_valid);

  assert_grant_follows_avail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && (!$past(grant_valid) || $past(grant_ready))) |-> $past(port_avail));

  assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=>
      (grant_valid && $stable(grant_port) && $stable(grant_id)));

  assert_repoll_between_grants_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready && !multi_burst_en) |=>
      !(grant_valid && (grant_port == $past(grant_port))));

endmodule

bind lp_poll_seq lp_poll_seq_chk #(.ID_W(ID_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_mode(link_mode), .pkt_mode(pkt_mode),
  .multi_burst_en(multi_burst_en), .port_avail(port_avail), .poll_valid(poll_valid),
  .grant_valid(grant_valid), .grant_ready(grant_ready),
  .grant_port(grant_port), .grant_id(grant_id)
);

// File: tb/lp_poll_seq_tb.sv
`timescale 1ns/1ps
module lp_poll_seq_tb;

  localparam int NIDS = 64;
  localparam int PW   = 6;
  localparam int IW   = 6;
  localparam int LAT  = 2;
  localparam int NP   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_mode = 1'b0, pkt_mode = 1'b0, multi_burst_en = 1'b0;
  logic [IW-1:0] poll_limit = '0;
  logic tbl_wr_en = 1'b0, tbl_wr_enable = 1'b0;
  logic [IW-1:0] tbl_wr_id = '0;
  logic [PW-1:0] tbl_wr_port = '0;
  logic port_avail = 1'b0, grant_ready = 1'b0;
  logic poll_valid, grant_valid;
  logic [PW-1:0] poll_addr, grant_port;
  logic [IW-1:0] grant_id;

  always #2.5 clk = ~clk;

  lp_poll_seq #(.NUM_IDS(NIDS), .PORT_W(PW), .POLL_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_mode(link_mode), .pkt_mode(pkt_mode),
    .poll_limit(poll_limit), .multi_burst_en(multi_burst_en),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_id(tbl_wr_id), .tbl_wr_port(tbl_wr_port),
    .tbl_wr_enable(tbl_wr_enable), .poll_valid(poll_valid), .poll_addr(poll_addr),
    .port_avail(port_avail), .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_port(grant_port), .grant_id(grant_id)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string phase_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int id; int port; bit en; } slot_t;
  slot_t fl[$];
  slot_t s_tmp;
  int  m_ptr, m_pa, m_gp, m_gid;
  bit  m_pv, m_gv;
  int  m_tbl_port [NIDS];
  bit  m_tbl_en   [NIDS];
  bit  m_blk      [NP];
  bit  act, hs, cand;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_pa = 0; m_pv = 0; m_gv = 0; m_gp = 0; m_gid = 0;
      fl.delete();
      for (int i = 0; i < NIDS; i++) begin m_tbl_port[i] = 0; m_tbl_en[i] = 0; end
      for (int i = 0; i < NP; i++) m_blk[i] = 0;
    end else begin
      act  = link_mode && pkt_mode;
      hs   = m_gv && grant_ready;
      cand = 0;
      if (act && fl.size() == LAT) begin
        s_tmp = fl.pop_front();
        cand = s_tmp.en && port_avail &&
               (multi_burst_en || (!m_blk[s_tmp.port] && !(hs && m_gp == s_tmp.port)));
      end
      if (m_pv) m_blk[m_pa] = 0;
      if (hs)   m_blk[m_gp] = 1;
      if (!m_gv || grant_ready) begin
        m_gv = cand;
        if (cand) begin m_gp = s_tmp.port; m_gid = s_tmp.id; end
      end
      if (act) begin
        slot_t n;
        n.id = m_ptr; n.port = m_tbl_port[m_ptr]; n.en = m_tbl_en[m_ptr];
        fl.push_back(n);
        m_pv = n.en; m_pa = n.port;
        m_ptr = (m_ptr >= int'(poll_limit)) ? 0 : m_ptr + 1;
      end else begin
        fl.delete(); m_pv = 0; m_ptr = 0;
      end
      if (tbl_wr_en) begin
        m_tbl_port[tbl_wr_id] = int'(tbl_wr_port);
        m_tbl_en[tbl_wr_id]   = tbl_wr_enable;
      end
    end
  end

  // ---------------- per-cycle compare and responders ----------------
  bit avail_all = 0;
  bit avail_mask [NP];
  int prev_addr = 0;
  int ready_mode = 0;   // 0 always ready, 1 never ready, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(poll_valid == m_pv, phase_req, "poll_valid", poll_valid, m_pv);
      if (m_pv) chk(int'(poll_addr) == m_pa, phase_req, "poll_addr", poll_addr, m_pa);
      chk(grant_valid == m_gv, phase_req, "grant_valid", grant_valid, m_gv);
      if (m_gv) begin
        chk(int'(grant_port) == m_gp, phase_req, "grant_port", grant_port, m_gp);
        chk(int'(grant_id) == m_gid, phase_req, "grant_id", grant_id, m_gid);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    port_avail = avail_all ? 1'b1 : avail_mask[prev_addr];
    prev_addr  = int'(poll_addr);
    case (ready_mode)
      0: grant_ready = 1'b1;
      1: grant_ready = 1'b0;
      default: grant_ready = lfsr[0];
    endcase
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_entry(input int id, input int port, input bit en);
    tbl_wr_en = 1'b1; tbl_wr_id = IW'(id); tbl_wr_port = PW'(port); tbl_wr_enable = en;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all-reqs actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    int g_port, g_id;
    for (int p = 0; p < NP; p++) avail_mask[p] = 0;
    cycles(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!poll_valid, "R1", "poll_valid after reset", poll_valid, 0);
    chk(!grant_valid, "R1", "grant_valid after reset", grant_valid, 0);

    // R3: full table, ascending scan with wrap at limit 5
    phase_req = "R3";
    for (int i = 0; i < NIDS; i++) wr_entry(i, (i * 5 + 3) % 64, 1'b1);
    poll_limit = 6'd5;
    link_mode = 1'b1; pkt_mode = 1'b1;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      chk(poll_valid == 1'b1, "R3", "poll_valid in scan", poll_valid, 1);
      chk(int'(poll_addr) == ((k % 6) * 5 + 3) % 64, "R3", "scan order addr",
          poll_addr, ((k % 6) * 5 + 3) % 64);
    end

    // R7 / R8: held grant, then random acceptance
    phase_req = "R7"; ready_mode = 1; avail_all = 1;
    cycles(6);
    chk(grant_valid == 1'b1, "R7", "grant present", grant_valid, 1);
    g_port = int'(grant_port); g_id = int'(grant_id);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(grant_valid && int'(grant_port) == g_port && int'(grant_id) == g_id,
          "R7", "held grant port", grant_port, g_port);
    end
    phase_req = "R8"; ready_mode = 2;
    cycles(60);

    // R11: lower limit while pointer is high
    phase_req = "R11"; ready_mode = 0; poll_limit = 6'd63;
    cycles(30);
    poll_limit = 6'd3;
    cycles(1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(poll_addr == 6'd3 || poll_addr == 6'd8 || poll_addr == 6'd13 || poll_addr == 6'd18,
          "R11", "addr within lowered window", poll_addr, 3);
    end

    // R4: live table rewrite
    phase_req = "R4";
    wr_entry(1, 40, 1'b1);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (poll_valid && poll_addr == 6'd40) cnt++;
    end
    chk(cnt > 0, "R4", "rewritten port polled", cnt, 2);

    // R6: disabled entries are never granted
    phase_req = "R6";
    for (int i = 0; i < 4; i++) wr_entry(i, i + 1, 1'b0);
    cycles(4);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (grant_valid || poll_valid) cnt++;
    end
    chk(cnt == 0, "R6", "grants from disabled ids", cnt, 0);

    // R5: answer latency, only port 20 answers
    phase_req = "R5"; avail_all = 0; avail_mask[20] = 1;
    poll_limit = 6'd1;
    wr_entry(0, 10, 1'b1);
    wr_entry(1, 20, 1'b1);
    cycles(4);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (grant_valid) begin
        cnt++;
        chk(grant_port == 6'd20 && grant_id == 6'd1, "R5", "grant port for answer",
            grant_port, 20);
      end
    end
    chk(cnt > 0, "R5", "grants seen", cnt, 10);

    // R9: single id, re-poll spacing gives one grant per three cycles
    phase_req = "R9"; avail_all = 1; multi_burst_en = 1'b0;
    poll_limit = 6'd0;
    wr_entry(0, 7, 1'b1);
    cycles(10);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (grant_valid) cnt++;
    end
    chk(cnt == 10, "R9", "grants in 30 cycles", cnt, 10);

    // R10: multiple bursts allowed back to back
    phase_req = "R10"; multi_burst_en = 1'b1;
    cycles(5);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (grant_valid) cnt++;
    end
    chk(cnt == 30, "R10", "grants in 30 cycles", cnt, 30);

    // R9 mixed: shared ports, random answers and random acceptance
    phase_req = "R9"; multi_burst_en = 1'b0; avail_all = 0; ready_mode = 2;
    for (int p = 0; p < NP; p++) avail_mask[p] = ((p * 7 + 3) % 3) != 0;
    for (int i = 0; i < 8; i++) wr_entry(i, (i % 3) + 1, (i != 5));
    poll_limit = 6'd7;
    cycles(200);

    // R2: inactive unless both flags set; restart at id 0
    phase_req = "R2"; ready_mode = 0;
    pkt_mode = 1'b0;
    cycles(2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!poll_valid && !grant_valid, "R2", "idle with packet flag low", poll_valid, 0);
    end
    pkt_mode = 1'b1; link_mode = 1'b0;
    cycles(2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!poll_valid && !grant_valid, "R2", "idle with link flag low", grant_valid, 0);
    end
    link_mode = 1'b1;
    @(negedge clk);
    chk(poll_valid == m_tbl_en[0] && int'(poll_addr) == m_tbl_port[0], "R2",
        "restart at id 0", poll_addr, m_tbl_port[0]);
    cycles(20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule